// File: doc/BRIEF.md
# SPI Flash Program Sequencer

This block sits on the host side of a serial NOR flash and runs one complete modify transaction for each accepted request. A request is a page program (start address, byte count and a byte stream supplied by the host), a sector erase or a whole-array erase. The block emits the byte sequence a serial flash expects on a byte-wide shifter interface. First comes a one-byte write-enable frame. Next comes a status read that confirms the write-enable latch took effect. Then the operation frame itself. Last come repeated status reads until the write-in-progress flag clears. Chip select is released between every frame.

The shifter below it moves one byte per handshake. The sequencer raises `spiStart` for one cycle with the byte on `spiTx`, and the shifter must latch that byte in the same cycle. The shifter later pulses `spiDone` with the byte clocked back on `spiRx`. Chip select falls in the cycle of the first `spiStart` of a frame and rises in the cycle after the last `spiDone`. Program data is pulled from the host: `dataTake` marks the cycle in which the byte on `dataIn` is being sent, and the host presents the next byte after it.

Invalid program requests are refused before any traffic. A latch that fails to set stops the transaction, and so does a device that stays busy too long. Each case is reported on `error` with a reason code.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, chip select is high, `busy`, `done`, `error`, `spiStart` and `dataTake` are low.
- R2: Every accepted request starts with a frame that holds only the byte 06h.
- R3: After the write-enable frame, a status frame of 05h then 00h is sent. If bit 1 of the byte returned for 00h is 0, the transaction stops with no operation frame, and `error` pulses with `errCode` = 2.
- R4: For `reqOp` = 0 (program), the operation frame is 02h, then the three address bytes most significant first, then `reqLen` data bytes taken from `dataIn` in stream order, with `dataTake` high once per data byte.
- R5: For `reqOp` = 1 the operation frame is D8h followed by the three address bytes most significant first. For `reqOp` = 2 it is the single byte C7h.
- R6: After the operation frame, status frames (05h, 00h) repeat until bit 0 of the returned byte is 0. Then `done` pulses for exactly one cycle, and `busy` is low from that cycle on. `busy` is high from the cycle after acceptance until then.
- R7: If `MaxPolls` status frames in a row all return bit 0 = 1, the transaction stops after the last of them, and `error` pulses with `errCode` = 3.
- R8: A request with `reqOp` = 3 is refused, and so is a program request whose `reqLen` is 0, above 256, or whose low address byte plus `reqLen` exceeds 256. `error` pulses in the next cycle with `errCode` = 1, chip select stays high and `busy` stays low.
- R9: Chip select is low for every byte transferred and returns high for at least one cycle between frames, so each command and each poll is its own frame.
- R10: `reqValid` is ignored while `busy` is high; the running byte sequence is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 invalid |
| reqAddr | input | 24 | Start address of program or sector address |
| reqLen | input | 9 | Program byte count, 1 to 256 |
| dataIn | input | 8 | Current program data byte from the host |
| dataTake | output | 1 | The byte on dataIn is sent in this cycle |
| spiCsN | output | 1 | Active-low chip select |
| spiStart | output | 1 | Start one byte transfer of spiTx |
| spiTx | output | 8 | Byte to transmit |
| spiDone | input | 1 | Byte transfer finished, spiRx valid |
| spiRx | input | 8 | Byte received during the transfer |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on refusal or abort |
| errCode | output | 2 | Reason for the last error: 1 bad request, 2 latch not set, 3 poll timeout |

## Verification
Suppose the frame phase or the byte counter inside the frame is wrong. The byte on `spiTx` at the very next `spiStart` then differs from the expected sequence. A framing fault shows as a changed count of chip-select frames once the transaction ends. A fault in the status capture or the poll counter shows within one poll frame. It appears as an early or missing `done`, or a wrong `errCode`. A data-stream mismatch appears at the first data byte, because the expected bytes are rebuilt from the request and compared as they leave.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BULK = 2'd2,
    OP_NONE = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    PH_WREN,
    PH_WELCHK,
    PH_OPER,
    PH_POLL
  } phase_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SEND,
    S_WAIT,
    S_EVAL
  } seqState_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_REQ     = 2'd1,
    ERR_WEL     = 2'd2,
    ERR_TIMEOUT = 2'd3
  } errCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   frameClr;
    logic   byteInc;
    logic   send;
    logic   capStatus;
    logic   pollClr;
    logic   pollInc;
    phase_t phase;
  } dpCtrl_t;

  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_RDSR = 8'h05;
  localparam logic [7:0] CMD_SECT = 8'hD8;
  localparam logic [7:0] CMD_BULK = 8'hC7;

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int PageBytes = 256,
  parameter int AddrBytes = 3,
  parameter int MaxPolls  = 4096
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtrl_t                       ctl,
  input  logic [1:0]                    reqOp,
  input  logic [AddrBytes*8-1:0]        reqAddr,
  input  logic [$clog2(PageBytes):0]    reqLen,
  input  logic [7:0]                    dataIn,
  input  logic [7:0]                    spiRx,
  output logic [7:0]                    txByte,
  output logic                          dataTake,
  output logic                          reqBad,
  output logic                          frameLast,
  output logic                          wip,
  output logic                          wel,
  output logic                          pollLast
);

  localparam int AddrW = AddrBytes * 8;
  localparam int PageW = $clog2(PageBytes);
  localparam int LenW  = PageW + 1;
  localparam int LenX  = LenW + 1;
  localparam int IdxW  = $clog2(PageBytes + AddrBytes + 1) + 1;
  localparam int PollW = $clog2(MaxPolls + 1);

  localparam logic [LenX-1:0]  PageLim  = LenX'(PageBytes);
  localparam logic [IdxW-1:0]  AddrLast = IdxW'(AddrBytes);
  localparam logic [PollW-1:0] PollMax  = PollW'(MaxPolls - 1);

  opKind_t          opQ;
  logic [AddrW-1:0] addrQ;
  logic [LenW-1:0]  lenQ;
  logic [IdxW-1:0]  byteIdx;
  logic [IdxW-1:0]  frameLen;
  logic [PollW-1:0] pollCnt;
  logic             welQ, wipQ;
  logic [AddrW-1:0] addrSh;
  logic [LenX-1:0]  pageOff, lenExt;
  logic             unusedRxHi;

  assign unusedRxHi = ^spiRx[7:2];

  // request screening
  assign pageOff = {{(LenX - PageW){1'b0}}, reqAddr[PageW-1:0]};
  assign lenExt  = {1'b0, reqLen};
  always_comb begin
    reqBad = 1'b0;
    if (reqOp == OP_NONE) begin
      reqBad = 1'b1;
    end else if (reqOp == OP_PROG) begin
      reqBad = (reqLen == '0) || (lenExt > PageLim) || ((pageOff + lenExt) > PageLim);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_NONE;
      addrQ <= '0;
      lenQ  <= '0;
    end else if (ctl.load) begin
      opQ   <= opKind_t'(reqOp);
      addrQ <= reqAddr;
      lenQ  <= reqLen;
    end
  end

  // byte position inside the current frame
  always_ff @(posedge clk) begin
    if (!rstN || ctl.frameClr) begin
      byteIdx <= '0;
    end else if (ctl.byteInc) begin
      byteIdx <= byteIdx + IdxW'(1);
    end
  end

  always_comb begin
    case (ctl.phase)
      PH_WREN:   frameLen = IdxW'(1);
      PH_WELCHK: frameLen = IdxW'(2);
      PH_POLL:   frameLen = IdxW'(2);
      default: begin
        case (opQ)
          OP_PROG: frameLen = IdxW'(1 + AddrBytes) + IdxW'(lenQ);
          OP_SECT: frameLen = IdxW'(1 + AddrBytes);
          default: frameLen = IdxW'(1);
        endcase
      end
    endcase
  end

  assign frameLast = (byteIdx == frameLen - IdxW'(1));

  // transmit byte selection
  assign addrSh = addrQ >> (8 * (AddrBytes - int'(byteIdx)));

  always_comb begin
    txByte = 8'h00;
    case (ctl.phase)
      PH_WREN: txByte = CMD_WREN;
      PH_WELCHK, PH_POLL: txByte = (byteIdx == '0) ? CMD_RDSR : 8'h00;
      default: begin
        if (byteIdx == '0) begin
          case (opQ)
            OP_PROG: txByte = CMD_PROG;
            OP_SECT: txByte = CMD_SECT;
            default: txByte = CMD_BULK;
          endcase
        end else if (byteIdx <= AddrLast) begin
          txByte = addrSh[7:0];
        end else begin
          txByte = dataIn;
        end
      end
    endcase
  end

  assign dataTake = ctl.send && (ctl.phase == PH_OPER) && (opQ == OP_PROG) && (byteIdx > AddrLast);

  // status capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ <= 1'b0;
      wipQ <= 1'b0;
    end else if (ctl.capStatus) begin
      welQ <= spiRx[1];
      wipQ <= spiRx[0];
    end
  end

  assign wel = welQ;
  assign wip = wipQ;

  // poll counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.pollClr) begin
      pollCnt <= '0;
    end else if (ctl.pollInc) begin
      pollCnt <= pollCnt + PollW'(1);
    end
  end

  assign pollLast = (pollCnt == PollMax);

  // R4
  idx_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.send |-> (byteIdx < frameLen));

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pollInc |-> (pollCnt < PollMax));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       spiDone,
  input  logic       frameLast,
  input  logic       wip,
  input  logic       wel,
  input  logic       pollLast,
  output dpCtrl_t    ctl,
  output logic       spiCsN,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [1:0] errCode
);

  seqState_t state, stateN;
  phase_t    phase, phaseN;
  logic      doneQ, doneN, errQ, errN;
  errCode_t  codeQ, codeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_WREN;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      codeQ <= ERR_NONE;
    end else begin
      state <= stateN;
      phase <= phaseN;
      doneQ <= doneN;
      errQ  <= errN;
      codeQ <= codeN;
    end
  end

  always_comb begin
    stateN    = state;
    phaseN    = phase;
    doneN     = 1'b0;
    errN      = 1'b0;
    codeN     = codeQ;
    ctl       = '0;
    ctl.phase = phase;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (reqBad) begin
            errN  = 1'b1;
            codeN = ERR_REQ;
          end else begin
            ctl.load     = 1'b1;
            ctl.frameClr = 1'b1;
            ctl.pollClr  = 1'b1;
            phaseN       = PH_WREN;
            codeN        = ERR_NONE;
            stateN       = S_SEND;
          end
        end
      end
      S_SEND: begin
        ctl.send = 1'b1;
        stateN   = S_WAIT;
      end
      S_WAIT: begin
        if (spiDone) begin
          if (frameLast) begin
            ctl.capStatus = 1'b1;
            stateN        = S_EVAL;
          end else begin
            ctl.byteInc = 1'b1;
            stateN      = S_SEND;
          end
        end
      end
      default: begin
        ctl.frameClr = 1'b1;
        stateN       = S_SEND;
        case (phase)
          PH_WREN: phaseN = PH_WELCHK;
          PH_WELCHK: begin
            if (wel) begin
              phaseN = PH_OPER;
            end else begin
              errN   = 1'b1;
              codeN  = ERR_WEL;
              stateN = S_IDLE;
            end
          end
          PH_OPER: phaseN = PH_POLL;
          default: begin
            if (!wip) begin
              doneN  = 1'b1;
              stateN = S_IDLE;
            end else if (pollLast) begin
              errN   = 1'b1;
              codeN  = ERR_TIMEOUT;
              stateN = S_IDLE;
            end else begin
              ctl.pollInc = 1'b1;
            end
          end
        endcase
      end
    endcase
  end

  assign spiCsN  = !((state == S_SEND) || (state == S_WAIT));
  assign busy    = (state != S_IDLE);
  assign done    = doneQ;
  assign error   = errQ;
  assign errCode = codeQ;

  // R6
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && errQ));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (state == S_IDLE));

  // R3
  wel_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVAL && phase == PH_WELCHK && !wel) |=> (errQ && codeQ == ERR_WEL && state == S_IDLE));

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid && reqBad) |=> (errQ && codeQ == ERR_REQ && state == S_IDLE));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int PageBytes = 256,
  parameter int AddrBytes = 3,
  parameter int MaxPolls  = 4096
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [1:0]                 reqOp,
  input  logic [AddrBytes*8-1:0]     reqAddr,
  input  logic [$clog2(PageBytes):0] reqLen,
  input  logic [7:0]                 dataIn,
  output logic                       dataTake,
  output logic                       spiCsN,
  output logic                       spiStart,
  output logic [7:0]                 spiTx,
  input  logic                       spiDone,
  input  logic [7:0]                 spiRx,
  output logic                       busy,
  output logic                       done,
  output logic                       error,
  output logic [1:0]                 errCode
);

  dpCtrl_t ctl;
  logic    reqBad, frameLast, wip, wel, pollLast;

  flash_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqBad    (reqBad),
    .spiDone   (spiDone),
    .frameLast (frameLast),
    .wip       (wip),
    .wel       (wel),
    .pollLast  (pollLast),
    .ctl       (ctl),
    .spiCsN    (spiCsN),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .errCode   (errCode)
  );

  flash_seq_dp #(
    .PageBytes (PageBytes),
    .AddrBytes (AddrBytes),
    .MaxPolls  (MaxPolls)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .dataIn    (dataIn),
    .spiRx     (spiRx),
    .txByte    (spiTx),
    .dataTake  (dataTake),
    .reqBad    (reqBad),
    .frameLast (frameLast),
    .wip       (wip),
    .wel       (wel),
    .pollLast  (pollLast)
  );

  assign spiStart = ctl.send;

endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

  localparam int MaxPolls = 6;

  logic       clk, rstN, reqValid;
  logic [1:0] reqOp;
  logic [23:0] reqAddr;
  logic [8:0] reqLen;
  logic [7:0] dataIn;
  logic       dataTake, spiCsN, spiStart;
  logic [7:0] spiTx;
  logic       spiDone;
  logic [7:0] spiRx;
  logic       busy, done, error;
  logic [1:0] errCode;

  flash_prog_seq #(.MaxPolls(MaxPolls)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqLen(reqLen), .dataIn(dataIn), .dataTake(dataTake), .spiCsN(spiCsN),
    .spiStart(spiStart), .spiTx(spiTx), .spiDone(spiDone), .spiRx(spiRx),
    .busy(busy), .done(done), .error(error), .errCode(errCode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // flash model state
  bit   welAcc, stuck, flWel;
  int   busyPolls, wipLeft, lat, frames;
  logic prevCs;
  logic [7:0] fr[$];

  // expected byte stream
  logic [7:0] expQ[$];
  string      tagQ[$];
  int         dataIdx;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 90) & 255);
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic pushB(input logic [7:0] b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  function automatic logic [7:0] resp();
    if (fr.size() >= 2 && fr[0] == 8'h05) return {6'b0, flWel, (wipLeft != 0)};
    return 8'hFF;
  endfunction

  task automatic endFrame();
    if (fr.size() == 1 && fr[0] == 8'h06) begin
      if (welAcc) flWel = 1;
    end else if (fr.size() > 0 && (fr[0] == 8'h02 || fr[0] == 8'hD8 || fr[0] == 8'hC7) && flWel) begin
      flWel = 0;
      wipLeft = busyPolls;
    end else if (fr.size() > 0 && fr[0] == 8'h05 && wipLeft > 0 && !stuck) begin
      wipLeft--;
    end
    fr.delete();
  endtask

  // per-cycle monitor and flash/shifter model
  always @(negedge clk) begin
    logic [7:0] b, e;
    string t;
    if (rstN) begin
      b = spiTx;
      if (spiStart) begin
        chk(!spiCsN, "R9", "chip select low on byte", spiCsN, 0);
        if (expQ.size() == 0) begin
          chk(0, "R10", "byte with nothing expected", b, 0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(b == e, t, "transmitted byte", b, e);
        end
      end
      if (dataTake) begin
        dataIdx++;
        dataIn = pat(dataIdx);
      end
      spiDone = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          spiDone = 1;
          spiRx = resp();
        end
      end
      if (spiStart && !spiCsN) begin
        fr.push_back(b);
        lat = 3;
      end
      if (!prevCs && spiCsN) begin
        frames++;
        endFrame();
      end
      prevCs = spiCsN;
    end
  end

  task automatic runOp(input string name, input logic [1:0] op, input logic [23:0] addr, input int len,
                       input int bp, input bit wa, input bit stk, input int expCode, input bit intrude);
    int f0, polls, cyc, expFrames;
    bit sawBusy, gotDone, gotErr;
    logic [1:0] code;
    string codeTag;
    busyPolls = bp; welAcc = wa; stuck = stk; wipLeft = 0; flWel = 0;
    dataIdx = 0; dataIn = pat(0);
    polls = stk ? MaxPolls : bp + 1;
    expQ.delete(); tagQ.delete();
    if (expCode != 1) begin
      pushB(8'h06, "R2");
      pushB(8'h05, "R3"); pushB(8'h00, "R3");
      if (wa) begin
        if (op == 2'd0) pushB(8'h02, "R4");
        else if (op == 2'd1) pushB(8'hD8, "R5");
        else pushB(8'hC7, "R5");
        if (op != 2'd2) begin
          pushB(addr[23:16], op == 2'd0 ? "R4" : "R5");
          pushB(addr[15:8],  op == 2'd0 ? "R4" : "R5");
          pushB(addr[7:0],   op == 2'd0 ? "R4" : "R5");
        end
        if (op == 2'd0) for (int i = 0; i < len; i++) pushB(pat(i), "R4");
        for (int p = 0; p < polls; p++) begin
          pushB(8'h05, stk ? "R7" : "R6");
          pushB(8'h00, stk ? "R7" : "R6");
        end
      end
    end
    expFrames = (expCode == 1) ? 0 : (wa ? 3 + polls : 2);
    f0 = frames;
    sawBusy = 0;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = addr; reqLen = 9'(len);
    @(negedge clk);
    reqValid = 0;
    cyc = 0;
    while (!(done || error) && cyc < 20000) begin
      if (busy) sawBusy = 1;
      if (expCode != 1) chk(busy, "R6", {name, " busy during op"}, busy, 1);
      cyc++;
      if (intrude && cyc == 20) begin
        reqValid = 1; reqOp = 2'd0; reqAddr = 24'h0; reqLen = 9'd4;
      end
      if (intrude && cyc == 21) reqValid = 0;
      @(negedge clk);
    end
    gotDone = done; gotErr = error; code = errCode;
    codeTag = (expCode == 1) ? "R8" : (expCode == 2) ? "R3" : (expCode == 3) ? "R7" : "R6";
    if (expCode == 0) begin
      chk(gotDone && !gotErr, "R6", {name, " done pulse"}, {gotDone, gotErr}, 2'b10);
    end else begin
      chk(gotErr && !gotDone, codeTag, {name, " error pulse"}, {gotDone, gotErr}, 2'b01);
      chk(code == 2'(expCode), codeTag, {name, " error code"}, code, expCode);
    end
    if (expCode == 1) chk(!sawBusy, "R8", {name, " busy stayed low"}, sawBusy, 0);
    chk(!busy, "R6", {name, " busy low at end"}, busy, 0);
    @(negedge clk);
    chk(!done && !error, "R6", {name, " single-cycle pulse"}, {done, error}, 0);
    chk(expQ.size() == 0, codeTag, {name, " bytes still expected"}, expQ.size(), 0);
    chk(frames - f0 == expFrames, "R9", {name, " frame count"}, frames - f0, expFrames);
    if (op == 2'd0 && expCode == 0)
      chk(dataIdx == len, "R4", {name, " data bytes taken"}, dataIdx, len);
    if (intrude) chk(!busy && !done, "R10", {name, " intruding request ignored"}, busy, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rstN = 0; reqValid = 0; reqOp = 0; reqAddr = 0; reqLen = 0;
    dataIn = 0; spiDone = 0; spiRx = 0;
    prevCs = 1; lat = 0; frames = 0; dataIdx = 0;
    repeat (3) @(negedge clk);
    chk(spiCsN && !busy && !done && !error && !spiStart && !dataTake, "R1", "reset state",
        {spiCsN, busy, done, error, spiStart, dataTake}, 6'b100000);
    rstN = 1;
    @(negedge clk);
    chk(spiCsN && !busy && !done && !error, "R1", "idle after reset", {spiCsN, busy, done, error}, 4'b1000);

    runOp("full page",   2'd0, 24'h123400, 256, 3, 1, 0, 0, 0);
    runOp("page tail",   2'd0, 24'h0000F0, 16,  0, 1, 0, 0, 0);
    runOp("last byte",   2'd0, 24'h7700FF, 1,   1, 1, 0, 0, 0);
    runOp("sector",      2'd1, 24'hABCDEF, 0,   2, 1, 0, 0, 1);
    runOp("bulk edge",   2'd2, 24'h000000, 0,   MaxPolls - 1, 1, 0, 0, 0);
    runOp("bulk stuck",  2'd2, 24'h000000, 0,   1, 1, 1, 3, 0);
    runOp("no latch",    2'd0, 24'h000010, 8,   0, 0, 0, 2, 0);
    runOp("zero len",    2'd0, 24'h000000, 0,   0, 1, 0, 1, 0);
    runOp("long len",    2'd0, 24'h000000, 257, 0, 1, 0, 1, 0);
    runOp("cross page",  2'd0, 24'h0000F1, 16,  0, 1, 0, 1, 0);
    runOp("bad op",      2'd3, 24'h000000, 4,   0, 1, 0, 1, 0);
    runOp("after rej",   2'd1, 24'h010000, 0,   0, 1, 0, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule